// File: doc/BRIEF.md
# Configuration-Mode Unlock Sequencer

This block is the configuration front end of a legacy I/O controller. It sits behind an index/data port pair on a byte-wide host I/O bus. The index port is the block's base address and the data port is the next address up. While the block is locked, every byte the host writes to the index port goes to a key matcher. When the four-byte unlock key has arrived in order, the block enters configuration mode.

In configuration mode the host writes a register index to the index port and then reads or writes that register through the data port. The register file holds a read-only chip ID, a logical-device select, and a flash-control register. The flash-control bits enable three memory-mapped flash segments, allow host writes to flash, choose a suspend state and pick a flash pin option. Registers at index 0x30 and above have a separate copy for each logical device. On the flash logical device, indices 0x64 and 0x65 hold the flash-controller base I/O address. Writing the exit code returns the block to the locked state.

The flash-control bits and the flash logical device's base address are exported continuously to the rest of the chip.

Top module: `cfg_unlock_port`

## Requirements
- R1: After reset the block is locked, the flash-control output is 0x00 and the flash base output is 0x0000. The read data is 0xFF.
- R2: The block enters configuration mode when the host writes the bytes 0x87, 0x01, 0x55 and K to the index port in that order. K is 0x55 when the base port is 0x2E and 0xAA when the base port is 0x4E. Configuration mode is visible on the cycle after the last key byte is written.
- R3: A byte that does not match the next expected key byte returns the matcher to its first step. If that byte is 0x87, it is taken as the first key byte and the match restarts at step one.
- R4: While the block is locked, reads of the data port return 0xFF and writes to the data port change no register.
- R5: In configuration mode, a write to the base port sets the register index. A read of the base port returns the current index. On entry to configuration mode the index is cleared to 0x00.
- R6: Index 0x20 reads 0x87 and index 0x21 reads 0x16. Both are read-only.
- R7: Writing 0x02 to index 0x02 leaves configuration mode on the next cycle. Any other value written there has no effect. After exit, the matcher starts again from its first step.
- R8: The flash-control register sits at index 0x24. Bit 0 is suspend, bits 1 to 3 enable three flash segments, bit 4 enables host flash writes and bit 5 selects the flash pin. Bits 7:6 read as 0. The register value drives the flash-control output.
- R9: Index 0x07 selects the logical device. Indices 0x64 (high byte) and 0x65 (low byte) are stored separately for each logical device. The flash base output is the 0x64/0x65 pair of logical device 7.
- R10: Unimplemented indices read 0x00 and ignore writes. This covers global indices below 0x30 and device indices other than 0x64 and 0x65. When the selected device number is 8 or more, device-specific registers read 0x00 and ignore writes.
- R11: Read data depends only on the current address and on state. It changes in the same cycle as the address and has no read strobe. An address that is neither the index port nor the data port reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | Host write strobe, one byte per cycle |
| io_addr_i | input | 16 | Host I/O address |
| io_wdata_i | input | 8 | Host write data |
| io_rdata_o | output | 8 | Read data for the current address |
| cfg_mode_o | output | 1 | Configuration mode active |
| flash_ctrl_o | output | 8 | Flash-control register value |
| flash_base_o | output | 16 | Flash-controller base I/O address held by logical device 7 |

## Verification
Two events can coincide with a read in the same cycle. The first is the write of the final key byte. The second is the write of the exit code, which the host makes while the data port is the address on the bus. The bench drives each of these writes and compares the read data in that same cycle, where it must still show the old mode, and again in the following cycle. A behavioural model is stepped at every clock edge and gives the expected values. A second instance at the other base port receives the same bus. This shows that each instance's last key byte is chosen by its own base port, and that writes addressed to one instance never move the other.

// File: rtl/cfg_unlock_pkg.sv
`timescale 1ns/1ps
package cfg_unlock_pkg;
  localparam logic [7:0] IDX_EXIT      = 8'h02;
  localparam logic [7:0] IDX_LDN       = 8'h07;
  localparam logic [7:0] IDX_ID_HI     = 8'h20;
  localparam logic [7:0] IDX_ID_LO     = 8'h21;
  localparam logic [7:0] IDX_FLASH     = 8'h24;
  localparam logic [7:0] IDX_DEV_FIRST = 8'h30;
  localparam logic [7:0] IDX_BASE_HI   = 8'h64;
  localparam logic [7:0] IDX_BASE_LO   = 8'h65;

  localparam logic [7:0] EXIT_CODE   = 8'h02;
  localparam logic [7:0] KEY0        = 8'h87;
  localparam logic [7:0] KEY1        = 8'h01;
  localparam logic [7:0] KEY2        = 8'h55;
  localparam logic [7:0] KEY_LAST_LO = 8'h55;
  localparam logic [7:0] KEY_LAST_HI = 8'hAA;
  localparam logic [7:0] LOCKED_READ = 8'hFF;

  localparam int FLASH_BITS = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GOT0,
    ST_GOT1,
    ST_GOT2
  } key_st_e;
endpackage

// File: rtl/cfg_key_matcher.sv
`timescale 1ns/1ps
module cfg_key_matcher
  import cfg_unlock_pkg::*;
#(
  parameter logic [7:0] LAST_KEY = 8'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic       hit_o
);
  key_st_e    st_q, st_d;
  logic [7:0] want;

  always_comb begin
    case (st_q)
      ST_IDLE: want = KEY0;
      ST_GOT0: want = KEY1;
      ST_GOT1: want = KEY2;
      default: want = LAST_KEY;
    endcase
  end

  assign hit_o = en_i && (st_q == ST_GOT2) && (byte_i == LAST_KEY);

  always_comb begin
    st_d = st_q;
    if (en_i) begin
      if (byte_i == want) begin
        case (st_q)
          ST_IDLE: st_d = ST_GOT0;
          ST_GOT0: st_d = ST_GOT1;
          ST_GOT1: st_d = ST_GOT2;
          default: st_d = ST_IDLE;
        endcase
      end else begin
        // a stray first-key byte counts as a fresh start
        st_d = (byte_i == KEY0) ? ST_GOT0 : ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/cfg_global_regs.sv
`timescale 1ns/1ps
module cfg_global_regs
  import cfg_unlock_pkg::*;
#(
  parameter logic [15:0] CHIP_ID = 16'h8716
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ldn_o,
  output logic [7:0] flash_ctrl_o,
  output logic       exit_o,
  output logic [7:0] rdata_o
);
  logic [7:0]            ldn_q;
  logic [FLASH_BITS-1:0] flash_q;

  assign exit_o       = wr_en_i && (idx_i == IDX_EXIT) && (wdata_i == EXIT_CODE);
  assign ldn_o        = ldn_q;
  assign flash_ctrl_o = {{(8-FLASH_BITS){1'b0}}, flash_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldn_q   <= '0;
      flash_q <= '0;
    end else if (wr_en_i) begin
      if (idx_i == IDX_LDN)   ldn_q   <= wdata_i;
      if (idx_i == IDX_FLASH) flash_q <= wdata_i[FLASH_BITS-1:0];
    end
  end

  always_comb begin
    case (idx_i)
      IDX_LDN:   rdata_o = ldn_q;
      IDX_ID_HI: rdata_o = CHIP_ID[15:8];
      IDX_ID_LO: rdata_o = CHIP_ID[7:0];
      IDX_FLASH: rdata_o = flash_ctrl_o;
      default:   rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfg_ldn_bank.sv
`timescale 1ns/1ps
module cfg_ldn_bank
  import cfg_unlock_pkg::*;
#(
  parameter int NUM_LDN   = 8,
  parameter int FLASH_LDN = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  ldn_i,
  input  logic [7:0]  idx_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic [15:0] base_o
);
  localparam int SEL_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

  logic [7:0]       hi_q [NUM_LDN];
  logic [7:0]       lo_q [NUM_LDN];
  logic             ldn_ok;
  logic [SEL_W-1:0] sel;

  assign ldn_ok = int'(ldn_i) < NUM_LDN;
  assign sel    = ldn_i[SEL_W-1:0];

  for (genvar l = 0; l < NUM_LDN; l++) begin : g_dev
    logic [7:0] hi_r, lo_r;
    logic       hit;
    assign hit = wr_en_i && (int'(ldn_i) == l);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_r <= '0;
        lo_r <= '0;
      end else if (hit) begin
        if (idx_i == IDX_BASE_HI) hi_r <= wdata_i;
        if (idx_i == IDX_BASE_LO) lo_r <= wdata_i;
      end
    end
    assign hi_q[l] = hi_r;
    assign lo_q[l] = lo_r;
  end

  always_comb begin
    rdata_o = 8'h00;
    if (ldn_ok) begin
      if (idx_i == IDX_BASE_HI) rdata_o = hi_q[sel];
      if (idx_i == IDX_BASE_LO) rdata_o = lo_q[sel];
    end
  end

  assign base_o = {hi_q[FLASH_LDN], lo_q[FLASH_LDN]};
endmodule

// File: rtl/cfg_unlock_port.sv
`timescale 1ns/1ps
module cfg_unlock_port
  import cfg_unlock_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_PORT = 'h2E,
  parameter logic [15:0]       CHIP_ID   = 16'h8716,
  parameter int                NUM_LDN   = 8,
  parameter int                FLASH_LDN = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              cfg_mode_o,
  output logic [7:0]        flash_ctrl_o,
  output logic [15:0]       flash_base_o
);
  localparam logic [ADDR_W-1:0] DATA_PORT = BASE_PORT + ADDR_W'(1);
  localparam logic [7:0] LAST_KEY = (BASE_PORT == ADDR_W'('h4E)) ? KEY_LAST_HI : KEY_LAST_LO;

  logic       cfg_q;
  logic [7:0] index_q;
  logic       idx_wr, data_wr, key_hit, exit_cmd, is_dev;
  logic [7:0] ldn, glb_rd, dev_rd;

  assign idx_wr  = io_wr_i && (io_addr_i == BASE_PORT);
  assign data_wr = io_wr_i && (io_addr_i == DATA_PORT) && cfg_q;
  assign is_dev  = index_q >= IDX_DEV_FIRST;

  cfg_key_matcher #(.LAST_KEY(LAST_KEY)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (idx_wr && !cfg_q),
    .byte_i (io_wdata_i),
    .hit_o  (key_hit)
  );

  cfg_global_regs #(.CHIP_ID(CHIP_ID)) u_glb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (data_wr && !is_dev),
    .idx_i        (index_q),
    .wdata_i      (io_wdata_i),
    .ldn_o        (ldn),
    .flash_ctrl_o (flash_ctrl_o),
    .exit_o       (exit_cmd),
    .rdata_o      (glb_rd)
  );

  cfg_ldn_bank #(.NUM_LDN(NUM_LDN), .FLASH_LDN(FLASH_LDN)) u_dev (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (data_wr && is_dev),
    .ldn_i   (ldn),
    .idx_i   (index_q),
    .wdata_i (io_wdata_i),
    .rdata_o (dev_rd),
    .base_o  (flash_base_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= 1'b0;
      index_q <= '0;
    end else begin
      if (key_hit)       cfg_q <= 1'b1;
      else if (exit_cmd) cfg_q <= 1'b0;
      if (key_hit)                index_q <= '0;
      else if (idx_wr && cfg_q)   index_q <= io_wdata_i;
    end
  end

  always_comb begin
    io_rdata_o = LOCKED_READ;
    if (cfg_q) begin
      if (io_addr_i == BASE_PORT)      io_rdata_o = index_q;
      else if (io_addr_i == DATA_PORT) io_rdata_o = is_dev ? dev_rd : glb_rd;
    end
  end

  assign cfg_mode_o = cfg_q;
endmodule

// File: rtl/cfg_unlock_checker.sv
`timescale 1ns/1ps
module cfg_unlock_checker #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_PORT = 'h2E,
  parameter logic [15:0]       CHIP_ID   = 16'h8716
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_wr_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o,
  input logic              cfg_mode_o,
  input logic [7:0]        flash_ctrl_o,
  input logic [7:0]        index_i
);
  localparam logic [ADDR_W-1:0] DATA_PORT = BASE_PORT + ADDR_W'(1);
  localparam logic [7:0] LAST_KEY = (BASE_PORT == ADDR_W'('h4E)) ? 8'hAA : 8'h55;

  p_locked_reads_ff_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_o |-> io_rdata_o == 8'hFF);

  p_locked_flash_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_o |=> $stable(flash_ctrl_o));

  p_unlock_last_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_o) |-> $past(io_wr_i && io_addr_i == BASE_PORT && io_wdata_i == LAST_KEY));

  p_exit_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && io_wr_i && io_addr_i == DATA_PORT && index_i == 8'h02 && io_wdata_i == 8'h02)
    |=> !cfg_mode_o);

  p_flash_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_ctrl_o[7:6] == 2'b00);

  p_chip_id_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && io_addr_i == DATA_PORT && index_i == 8'h20) |-> io_rdata_o == CHIP_ID[15:8]);
endmodule

bind cfg_unlock_port cfg_unlock_checker #(
  .ADDR_W    (ADDR_W),
  .BASE_PORT (BASE_PORT),
  .CHIP_ID   (CHIP_ID)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .io_wr_i      (io_wr_i),
  .io_addr_i    (io_addr_i),
  .io_wdata_i   (io_wdata_i),
  .io_rdata_o   (io_rdata_o),
  .cfg_mode_o   (cfg_mode_o),
  .flash_ctrl_o (flash_ctrl_o),
  .index_i      (index_q)
);

// File: tb/test_cfg_unlock_port.sv
`timescale 1ns/1ps
module test_cfg_unlock_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  wdata = 8'h0;
  logic [7:0]  rd0, rd1, fc0, fc1;
  logic        m0, m1;
  logic [15:0] fb0, fb1;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cfg_unlock_port i_cfg_unlock_port (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(wr), .io_addr_i(addr), .io_wdata_i(wdata),
    .io_rdata_o(rd0), .cfg_mode_o(m0), .flash_ctrl_o(fc0), .flash_base_o(fb0));

  cfg_unlock_port #(.BASE_PORT(16'h004E)) i_alt (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(wr), .io_addr_i(addr), .io_wdata_i(wdata),
    .io_rdata_o(rd1), .cfg_mode_o(m1), .flash_ctrl_o(fc1), .flash_base_o(fb1));

  // behavioural model, one slot per instance
  int m_mode [2];
  int m_step [2];
  int m_idx  [2];
  int m_ldn  [2];
  int m_fctl [2];
  int m_hi   [2][256];
  int m_lo   [2][256];

  function automatic int base_of(int i);
    return (i == 0) ? 'h2E : 'h4E;
  endfunction

  function automatic int key_of(int i, int s);
    case (s)
      0: return 'h87;
      1: return 'h01;
      2: return 'h55;
      default: return (i == 0) ? 'h55 : 'hAA;
    endcase
  endfunction

  function automatic int exp_rd(int i, int a);
    if (m_mode[i] == 0) return 'hFF;
    if (a == base_of(i)) return m_idx[i];
    if (a != base_of(i) + 1) return 'hFF;
    if (m_idx[i] < 'h30) begin
      case (m_idx[i])
        'h07: return m_ldn[i];
        'h20: return 'h87;
        'h21: return 'h16;
        'h24: return m_fctl[i];
        default: return 0;
      endcase
    end
    if (m_ldn[i] >= 8) return 0;
    if (m_idx[i] == 'h64) return m_hi[i][m_ldn[i]];
    if (m_idx[i] == 'h65) return m_lo[i][m_ldn[i]];
    return 0;
  endfunction

  task automatic model_update(int i);
    int b = base_of(i);
    int a = int'(addr);
    int d = int'(wdata);
    if (!wr) return;
    if (m_mode[i] == 0) begin
      if (a == b) begin
        if (d == key_of(i, m_step[i])) begin
          if (m_step[i] == 3) begin
            m_mode[i] = 1; m_step[i] = 0; m_idx[i] = 0;
          end else m_step[i]++;
        end else m_step[i] = (d == 'h87) ? 1 : 0;
      end
    end else if (a == b) begin
      m_idx[i] = d;
    end else if (a == b + 1) begin
      if (m_idx[i] < 'h30) begin
        if (m_idx[i] == 'h02 && d == 'h02) m_mode[i] = 0;
        if (m_idx[i] == 'h07) m_ldn[i] = d;
        if (m_idx[i] == 'h24) m_fctl[i] = d & 'h3F;
      end else if (m_ldn[i] < 8) begin
        if (m_idx[i] == 'h64) m_hi[i][m_ldn[i]] = d;
        if (m_idx[i] == 'h65) m_lo[i][m_ldn[i]] = d;
      end
    end
  endtask

  task automatic chk(int act, int exp, string tag, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(int'(rd0), exp_rd(0, int'(addr)), tag, "rdata main");
    chk(int'(m0), m_mode[0], tag, "mode main");
    chk(int'(fc0), m_fctl[0], tag, "flash_ctrl main");
    chk(int'(fb0), (m_hi[0][7] << 8) | m_lo[0][7], tag, "flash_base main");
    chk(int'(rd1), exp_rd(1, int'(addr)), tag, "rdata alt");
    chk(int'(m1), m_mode[1], tag, "mode alt");
    chk(int'(fc1), m_fctl[1], tag, "flash_ctrl alt");
    chk(int'(fb1), (m_hi[1][7] << 8) | m_lo[1][7], tag, "flash_base alt");
  endtask

  task automatic cyc(bit w, int a, int d, string tag);
    @(negedge clk);
    wr = w; addr = a[15:0]; wdata = d[7:0];
    #1 compare_all(tag);
    @(posedge clk);
    if (rst_n) begin
      model_update(0);
      model_update(1);
    end
  endtask

  task automatic put(int a, int d, string tag);
    cyc(1'b1, a, d, tag);
  endtask

  task automatic look(int a, string tag);
    cyc(1'b0, a, 0, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_mode[i] = 0; m_step[i] = 0; m_idx[i] = 0; m_ldn[i] = 0; m_fctl[i] = 0;
      for (int k = 0; k < 256; k++) begin m_hi[i][k] = 0; m_lo[i][k] = 0; end
    end
    // R1 reset state
    look('h2F, "R1");
    look('h2E, "R1");
    @(negedge clk) rst_n = 1'b1;
    look('h2F, "R1");
    chk(int'(rd0), 'hFF, "R1", "reset rdata");
    chk(int'(fc0), 0, "R1", "reset flash_ctrl");

    // R4 locked data port
    put('h2F, 'h3F, "R4");
    look('h2F, "R4");
    chk(int'(fc0), 0, "R4", "locked write ignored");

    // R3 broken sequences, then a 0x87 restart
    put('h2E, 'h87, "R3"); put('h2E, 'h01, "R3"); put('h2E, 'h87, "R3");
    put('h2E, 'h01, "R3"); put('h2E, 'h55, "R3"); put('h2E, 'h12, "R3");
    look('h2E, "R3");
    chk(int'(m0), 0, "R3", "broken key stays locked");
    put('h2E, 'h87, "R3"); put('h2E, 'h87, "R3"); put('h2E, 'h01, "R3");
    put('h2E, 'h55, "R2");
    put('h2E, 'h55, "R2"); // last key byte: same-cycle read still locked
    #1 chk(int'(m0), 1, "R2", "unlock main");
    chk(int'(m1), 0, "R2", "alt untouched");

    // R11 foreign address
    look('h10, "R11");
    chk(int'(rd0), 'hFF, "R11", "foreign address");

    // R5 index
    look('h2E, "R5");
    put('h2E, 'h24, "R5");
    look('h2E, "R5");
    chk(int'(rd0), 'h24, "R5", "index readback");

    // R8 flash control
    put('h2F, 'hFF, "R8"); look('h2F, "R8");
    chk(int'(rd0), 'h3F, "R8", "upper bits clear");
    put('h2F, 'h12, "R8"); look('h2F, "R8");

    // R6 chip id
    put('h2E, 'h20, "R6"); look('h2F, "R6");
    chk(int'(rd0), 'h87, "R6", "id high");
    put('h2F, 'h00, "R6"); look('h2F, "R6");
    put('h2E, 'h21, "R6"); look('h2F, "R6");
    chk(int'(rd0), 'h16, "R6", "id low");

    // R9 logical devices and flash base
    put('h2E, 'h07, "R9"); put('h2F, 'h07, "R9");
    put('h2E, 'h64, "R9"); put('h2F, 'h0A, "R9");
    put('h2E, 'h65, "R9"); put('h2F, 'h30, "R9");
    look('h2F, "R9");
    chk(int'(fb0), 'h0A30, "R9", "flash base");
    put('h2E, 'h07, "R9"); put('h2F, 'h03, "R9");
    put('h2E, 'h64, "R9"); put('h2F, 'h55, "R9"); look('h2F, "R9");
    chk(int'(fb0), 'h0A30, "R9", "other device separate");
    put('h2E, 'h07, "R9"); put('h2F, 'h07, "R9");
    put('h2E, 'h64, "R9"); look('h2F, "R9");
    chk(int'(rd0), 'h0A, "R9", "device 7 readback");

    // R10 unimplemented and out-of-range device
    put('h2E, 'h40, "R10"); look('h2F, "R10");
    put('h2E, 'h31, "R10"); put('h2F, 'h77, "R10"); look('h2F, "R10");
    put('h2E, 'h25, "R10"); put('h2F, 'h66, "R10"); look('h2F, "R10");
    put('h2E, 'h07, "R10"); put('h2F, 'h20, "R10");
    put('h2E, 'h64, "R10"); put('h2F, 'h99, "R10"); look('h2F, "R10");
    chk(int'(rd0), 0, "R10", "device 0x20 reads zero");

    // R7 exit
    put('h2E, 'h02, "R7"); put('h2F, 'h01, "R7");
    look('h2F, "R7");
    chk(int'(m0), 1, "R7", "wrong exit code");
    put('h2F, 'h02, "R7"); // same-cycle read still unlocked
    look('h2F, "R7");
    chk(int'(m0), 0, "R7", "exit");
    put('h2E, 'h87, "R7"); put('h2E, 'h01, "R7"); put('h2E, 'h55, "R7");
    put('h2E, 'hAA, "R2"); look('h2F, "R2");
    chk(int'(m0), 0, "R2", "wrong last key at 0x2E");
    put('h2E, 'h87, "R7"); put('h2E, 'h01, "R7"); put('h2E, 'h55, "R7");
    put('h2E, 'h55, "R7"); look('h2E, "R5");
    chk(int'(rd0), 0, "R5", "index cleared on entry");

    // R2 alternate base
    put('h4E, 'h87, "R2"); put('h4E, 'h01, "R2"); put('h4E, 'h55, "R2");
    put('h4E, 'h55, "R2"); look('h4F, "R2");
    chk(int'(m1), 0, "R2", "0x55 last key at 0x4E");
    put('h4E, 'h87, "R2"); put('h4E, 'h01, "R2"); put('h4E, 'h55, "R2");
    put('h4E, 'hAA, "R2"); look('h4F, "R2");
    chk(int'(m1), 1, "R2", "0xAA last key at 0x4E");
    put('h4E, 'h20, "R6"); look('h4F, "R6");
    chk(int'(rd1), 'h87, "R6", "alt id");
    put('h4E, 'h24, "R8"); put('h4F, 'h0E, "R8"); look('h2F, "R8");
    chk(int'(fc0), 'h12, "R8", "main unaffected by alt");
    finish_run();
  end
endmodule